// File: doc/BRIEF.md
# Scratchpad Bank Transfer Engine

The engine moves bytes between a processor register file and a set of scratchpad banks, one byte per clock. Every bank is laid out exactly like the register file: a byte at register index r and lane b in a bank pairs with register r, lane b in the register file. A transfer never relocates data.

A command names an operation, a device ID, a first register, a first byte lane and a byte count. Three operations exist:

- pull, which copies bank bytes into registers;
- push, which copies register bytes into a bank;
- swap, which exchanges register bytes and bank bytes.

Two reserved device IDs turn a pull into a fill of the addressed register bytes with all-ones or all-zeros. The register file stays outside the block and is reached through a byte-wide port. The block drives a register index, a lane, a write strobe and write data, and it takes the addressed byte back combinationally.

Top module: `scratch_xfer`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `err` and `rf_we` are low.
- R2: A pull (op 0) from device 10, 11, 12 or 14 (banks 0 to 3) writes each addressed bank byte into the same register and lane. Every other register byte keeps its value.
- R3: A push (op 1) to banks 10, 11, 12 or 14 stores each addressed register byte at the same register and lane of that bank. Every other bank byte keeps its value.
- R4: A swap (op 2) with a bank ID puts the old register byte into the bank and the old bank byte into the register, for every byte in the range.
- R5: A pull with device 254 writes 0xFF into each addressed register byte, and a pull with device 255 writes 0x00. No other byte changes.
- R6: The lane starts at `cmd_lane` and rises by one per byte. After lane 3 it returns to 0 and the register index rises by one. After register 31 the index returns to 0.
- R7: An accepted command of length N>0 holds `busy` high for exactly N cycles, starting the cycle after acceptance. `done` pulses for one cycle in the cycle after the last byte, and `busy` is low in that cycle.
- R8: An unsupported combination raises `err` and `done` for one cycle, in the cycle after acceptance, and writes no register or bank byte. Unsupported means any other device ID, a fill ID with op 1 or op 2, or op 3.
- R9: A length of zero pulses `done` without `err` in the next cycle and writes nothing.
- R10: `cmd_valid` while `busy` is high is ignored: the running transfer completes unchanged, with a single `done`.
- R11: Banks are independent. Writing one bank leaves the contents of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken when not busy |
| cmd_op | input | 2 | 0 pull, 1 push, 2 swap, 3 reserved |
| cmd_dev | input | 8 | Device ID (bank or fill ID) |
| cmd_reg | input | 5 | First register index |
| cmd_lane | input | 2 | First byte lane |
| cmd_len | input | 8 | Byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle unsupported-device pulse, with done |
| rf_idx | output | 5 | Register index being accessed |
| rf_lane | output | 2 | Byte lane being accessed |
| rf_we | output | 1 | Register byte write strobe |
| rf_wdata | output | 8 | Register byte write data |
| rf_rdata | input | 8 | Register byte at rf_idx/rf_lane |

## Verification
A command driven before edge E0 shows `busy` after E0 when it is a real transfer. A rejected or zero-length command instead shows `done` after E0, with `err` set for a rejected one. In a transfer of N bytes, the final byte is committed at edge EN, and `done` appears with `busy` low right after EN.

The bench drives commands on the falling edge and counts `busy` cycles on later falling edges. It expects `done` exactly when `busy` first reads low, and expects `done` to have cleared one falling edge later.

Register contents are compared only after completion. Bank contents are compared by pulling a whole bank back into the register file and checking it against a model computed in the bench.

// File: rtl/scratch_xfer_pkg.sv
package scratch_xfer_pkg;
  typedef enum logic [1:0] {
    XOP_PULL = 2'd0,
    XOP_PUSH = 2'd1,
    XOP_SWAP = 2'd2,
    XOP_RSVD = 2'd3
  } xop_e;

  localparam int unsigned DEV_W = 8;
  localparam logic [DEV_W-1:0] FILL_ONES_ID = 8'd254;
  localparam logic [DEV_W-1:0] FILL_ZERO_ID = 8'd255;
endpackage

// File: rtl/scratch_xfer_decode.sv
module scratch_xfer_decode
  import scratch_xfer_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 2,
  parameter logic [NUM_BANKS*DEV_W-1:0] BANK_IDS = {8'd14, 8'd12, 8'd11, 8'd10}
) (
  input  logic [1:0]       op,
  input  logic [DEV_W-1:0] dev,
  output logic             ok,
  output logic             is_fill,
  output logic [7:0]       fill_byte,
  output logic [BANK_W-1:0] bank
);
  logic [NUM_BANKS-1:0] hit;
  logic                 bank_hit;

  // one comparator per bank ID
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_hit
    assign hit[g] = (dev == BANK_IDS[g*DEV_W +: DEV_W]);
  end

  always_comb begin
    bank = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (hit[i]) bank = BANK_W'(i);
    end
  end

  assign bank_hit  = |hit;
  assign is_fill   = (dev == FILL_ONES_ID) || (dev == FILL_ZERO_ID);
  assign fill_byte = (dev == FILL_ONES_ID) ? 8'hFF : 8'h00;

  always_comb begin
    unique case (xop_e'(op))
      XOP_PULL: ok = bank_hit | is_fill;
      XOP_PUSH: ok = bank_hit;
      XOP_SWAP: ok = bank_hit;
      default:  ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/scratch_xfer_cursor.sv
module scratch_xfer_cursor #(
  parameter int unsigned NUM_REGS   = 32,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned REG_W      = 5,
  parameter int unsigned LANE_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [REG_W-1:0]  start_reg,
  input  logic [LANE_W-1:0] start_lane,
  input  logic [LEN_W-1:0]  len,
  output logic              busy,
  output logic [REG_W-1:0]  cur_reg,
  output logic [LANE_W-1:0] cur_lane,
  output logic              last
);
  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cur_reg  <= '0;
      cur_lane <= '0;
      left_q   <= '0;
    end else if (load && len != '0) begin
      busy     <= 1'b1;
      cur_reg  <= start_reg;
      cur_lane <= start_lane;
      left_q   <= len;
    end else if (busy) begin
      if (left_q == LEN_W'(1)) busy <= 1'b0;
      left_q <= left_q - 1'b1;
      if (cur_lane == LANE_W'(WORD_BYTES - 1)) begin
        cur_lane <= '0;
        cur_reg  <= (cur_reg == REG_W'(NUM_REGS - 1)) ? '0 : cur_reg + 1'b1;
      end else begin
        cur_lane <= cur_lane + 1'b1;
      end
    end
  end

  assign last = busy && (left_q == LEN_W'(1));
endmodule

// File: rtl/scratch_xfer_store.sv
module scratch_xfer_store #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned BANK_W    = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic [7:0] rd_bank [NUM_BANKS];

  // one byte-wide memory per bank, asynchronous read
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && bank == BANK_W'(g)) mem[addr] <= wdata;
    end
    assign rd_bank[g] = mem[addr];
  end

  assign rdata = rd_bank[bank];
endmodule

// File: rtl/scratch_xfer.sv
module scratch_xfer
  import scratch_xfer_pkg::*;
#(
  parameter int unsigned NUM_REGS   = 32,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned NUM_BANKS  = 4,
  parameter logic [NUM_BANKS*8-1:0] BANK_IDS = {8'd14, 8'd12, 8'd11, 8'd10},
  localparam int unsigned REG_W  = $clog2(NUM_REGS),
  localparam int unsigned LANE_W = $clog2(WORD_BYTES),
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned ADDR_W = REG_W + LANE_W,
  localparam int unsigned DEPTH  = NUM_REGS * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [7:0]        cmd_dev,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [LANE_W-1:0] cmd_lane,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [REG_W-1:0]  rf_idx,
  output logic [LANE_W-1:0] rf_lane,
  output logic              rf_we,
  output logic [7:0]        rf_wdata,
  input  logic [7:0]        rf_rdata
);
  logic              accept, dec_ok, dec_fill, last;
  logic [7:0]        dec_fill_byte, bank_rd;
  logic [BANK_W-1:0] dec_bank, bank_q;
  xop_e              op_q;
  logic              fill_q;
  logic [7:0]        fill_byte_q;
  logic              bank_we;

  assign accept = cmd_valid && !busy;

  scratch_xfer_decode #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .BANK_IDS(BANK_IDS)
  ) u_decode (
    .op(cmd_op), .dev(cmd_dev), .ok(dec_ok), .is_fill(dec_fill),
    .fill_byte(dec_fill_byte), .bank(dec_bank)
  );

  scratch_xfer_cursor #(
    .NUM_REGS(NUM_REGS), .WORD_BYTES(WORD_BYTES), .LEN_W(LEN_W),
    .REG_W(REG_W), .LANE_W(LANE_W)
  ) u_cursor (
    .clk(clk), .rst(rst), .load(accept && dec_ok),
    .start_reg(cmd_reg), .start_lane(cmd_lane), .len(cmd_len),
    .busy(busy), .cur_reg(rf_idx), .cur_lane(rf_lane), .last(last)
  );

  // command context held for the whole transfer
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q        <= XOP_PULL;
      bank_q      <= '0;
      fill_q      <= 1'b0;
      fill_byte_q <= 8'h00;
    end else if (accept && dec_ok) begin
      op_q        <= xop_e'(cmd_op);
      bank_q      <= dec_bank;
      fill_q      <= dec_fill;
      fill_byte_q <= dec_fill_byte;
    end
  end

  // completion and error pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= (accept && (!dec_ok || cmd_len == '0)) || last;
      err  <= accept && !dec_ok;
    end
  end

  scratch_xfer_store #(
    .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) u_store (
    .clk(clk), .we(bank_we), .bank(bank_q), .addr({rf_idx, rf_lane}),
    .wdata(rf_rdata), .rdata(bank_rd)
  );

  // both old bytes are read in the same cycle; both writes land on one edge
  assign bank_we  = busy && (op_q == XOP_PUSH || op_q == XOP_SWAP);
  assign rf_we    = busy && (op_q == XOP_PULL || op_q == XOP_SWAP);
  assign rf_wdata = fill_q ? fill_byte_q : bank_rd;
endmodule

// File: rtl/scratch_xfer_checker.sv
module scratch_xfer_checker #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned REG_W    = 5,
  parameter int unsigned LANE_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              rf_we,
  input logic [REG_W-1:0]  rf_idx,
  input logic [LANE_W-1:0] rf_lane
);
  assert_we_only_busy_R2: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> busy);

  assert_lane_step_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && rf_lane != '1) |=> (!busy ||
      (rf_lane == $past(rf_lane) + 1'b1 && rf_idx == $past(rf_idx))));

  assert_lane_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && rf_lane == '1) |=> (!busy || (rf_lane == '0 &&
      rf_idx == (($past(rf_idx) == REG_W'(NUM_REGS - 1)) ? '0 : $past(rf_idx) + 1'b1))));

  assert_done_at_end_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && !busy));

  assert_ignore_when_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> (busy || (done && !err)));
endmodule

bind scratch_xfer scratch_xfer_checker #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .LANE_W(LANE_W)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .err(err), .rf_we(rf_we), .rf_idx(rf_idx), .rf_lane(rf_lane)
);

// File: tb/scratch_xfer_bench.sv
module scratch_xfer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_dev = 8'd0;
  logic [4:0] cmd_reg = 5'd0;
  logic [1:0] cmd_lane = 2'd0;
  logic [7:0] cmd_len = 8'd0;
  logic       busy, done, err, rf_we;
  logic [4:0] rf_idx;
  logic [1:0] rf_lane;
  logic [7:0] rf_wdata, rf_rdata;

  // register file model outside the block, plus a bench load port
  logic [3:0][7:0] rf_mem [32];
  logic            ld_en = 1'b0;
  logic [4:0]      ld_idx = 5'd0;
  logic [31:0]     ld_word = 32'd0;

  logic [3:0][7:0] exp_rf [32];
  logic [3:0][7:0] exp_bk [4][32];
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  scratch_xfer u_scratch_xfer (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_dev(cmd_dev), .cmd_reg(cmd_reg), .cmd_lane(cmd_lane), .cmd_len(cmd_len),
    .busy(busy), .done(done), .err(err), .rf_idx(rf_idx), .rf_lane(rf_lane),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  assign rf_rdata = rf_mem[rf_idx][rf_lane];

  always @(posedge clk) begin
    if (ld_en) rf_mem[ld_idx] <= ld_word;
    else if (rf_we) rf_mem[rf_idx][rf_lane] <= rf_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic int bidx(input logic [7:0] d);
    case (d)
      8'd10: return 0;
      8'd11: return 1;
      8'd12: return 2;
      8'd14: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic bit cmd_ok(input logic [1:0] op, input logic [7:0] d);
    if (op == 2'd0) return (bidx(d) >= 0) || d == 8'd254 || d == 8'd255;
    if (op == 2'd1 || op == 2'd2) return bidx(d) >= 0;
    return 1'b0;
  endfunction

  task automatic model_apply(input logic [1:0] op, input logic [7:0] d,
                             input int r0, input int l0, input int len);
    int r = r0;
    int l = l0;
    int b = bidx(d);
    for (int n = 0; n < len; n++) begin
      logic [7:0] rv = exp_rf[r][l];
      if (op == 2'd0) begin
        if (d == 8'd254) exp_rf[r][l] = 8'hFF;
        else if (d == 8'd255) exp_rf[r][l] = 8'h00;
        else exp_rf[r][l] = exp_bk[b][r][l];
      end else if (op == 2'd1) begin
        exp_bk[b][r][l] = rv;
      end else begin
        exp_rf[r][l] = exp_bk[b][r][l];
        exp_bk[b][r][l] = rv;
      end
      l++;
      if (l == 4) begin
        l = 0;
        r = (r + 1) % 32;
      end
    end
  endtask

  task automatic cmp_rf(input string tag);
    bit ok = 1'b1;
    logic [31:0] a = '0;
    logic [31:0] e = '0;
    for (int i = 0; i < 32; i++) begin
      if (ok && rf_mem[i] !== exp_rf[i]) begin
        ok = 1'b0;
        a = rf_mem[i];
        e = exp_rf[i];
      end
    end
    chk(ok, tag, a, e);
  endtask

  task automatic preload(input int seed);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      ld_en = 1'b1;
      ld_idx = 5'(i);
      ld_word = 32'(seed) * 32'h9E3779B1 ^ (32'(i) * 32'h01030507) ^ 32'(i << 3);
      exp_rf[i] = ld_word;
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] d, input int r,
                         input int l, input int len, input string tag, input bit poke);
    bit v = cmd_ok(op, d);
    int cyc = 0;
    bit extra = 1'b0;
    @(negedge clk);
    cmd_op = op; cmd_dev = d; cmd_reg = 5'(r); cmd_lane = 2'(l); cmd_len = 8'(len);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!v) begin
      chk(done && err && !busy, {tag, " R8 err pulse"}, {busy, done, err}, 3'b011);
    end else if (len == 0) begin
      chk(done && !err && !busy, {tag, " R9 zero length"}, {busy, done, err}, 3'b010);
    end else begin
      while (busy && cyc < 400) begin
        if (done) extra = 1'b1;
        cyc++;
        if (poke && cyc == 2) begin
          cmd_op = 2'd0; cmd_dev = 8'd254; cmd_reg = 5'd0; cmd_lane = 2'd0;
          cmd_len = 8'd4; cmd_valid = 1'b1;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
      end
      chk(cyc == len, {tag, " R7 busy cycles"}, cyc, len);
      chk(done && !err && !extra, {tag, " R7 done pulse"}, {extra, done, err}, 3'b010);
    end
    @(negedge clk);
    chk(!done && !busy, {tag, poke ? " R10 single done" : " R7 pulse clears"},
        {busy, done}, 2'b00);
    if (v) model_apply(op, d, r, l, len);
    cmp_rf({tag, " registers"});
  endtask

  task automatic dump_bank(input int k, input string tag);
    logic [7:0] ids [4] = '{8'd10, 8'd11, 8'd12, 8'd14};
    run_cmd(2'd0, ids[k], 0, 0, 128, tag, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] ids [4] = '{8'd10, 8'd11, 8'd12, 8'd14};
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !rf_we, "R1 in reset",
        {busy, done, err, rf_we}, 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !rf_we, "R1 after reset",
        {busy, done, err, rf_we}, 4'b0000);

    // fill each bank with a distinct image (R3), read back each (R2, R11)
    for (int k = 0; k < 4; k++) begin
      preload(k + 1);
      run_cmd(2'd1, ids[k], 0, 0, 128, "R3 push full", 1'b0);
    end
    preload(9);
    for (int k = 0; k < 4; k++) dump_bank(k, "R11 R2 bank image");

    preload(21);
    run_cmd(2'd0, 8'd11, 5, 2, 9, "R2 R6 partial pull", 1'b0);
    run_cmd(2'd1, 8'd12, 30, 3, 7, "R3 R6 push reg wrap", 1'b0);
    run_cmd(2'd0, 8'd10, 31, 2, 7, "R6 pull reg wrap", 1'b0);
    run_cmd(2'd2, 8'd14, 7, 1, 10, "R4 swap", 1'b0);
    run_cmd(2'd0, 8'd254, 3, 1, 6, "R5 fill ones", 1'b0);
    run_cmd(2'd0, 8'd255, 20, 3, 5, "R5 fill zeros", 1'b0);

    run_cmd(2'd0, 8'd13, 0, 0, 4, "R8 bad dev", 1'b0);
    run_cmd(2'd1, 8'd254, 0, 0, 4, "R8 fill push", 1'b0);
    run_cmd(2'd2, 8'd255, 0, 0, 4, "R8 fill swap", 1'b0);
    run_cmd(2'd3, 8'd10, 0, 0, 4, "R8 op3", 1'b0);
    run_cmd(2'd1, 8'd10, 0, 0, 0, "R9 zero len", 1'b0);
    run_cmd(2'd1, 8'd10, 12, 0, 8, "R10 poke", 1'b1);

    // sweep of ops, start lanes and lengths over rotating banks
    for (int op = 0; op < 3; op++)
      for (int l = 0; l < 4; l++)
        for (int n = 1; n <= 6; n++)
          run_cmd(2'(op), ids[(op + l + n) % 4], (l * 5 + n * 3) % 32, l, n,
                  "R6 sweep", 1'b0);

    preload(33);
    for (int k = 0; k < 4; k++) dump_bank(k, "R3 R4 R8 R9 R11 final bank");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule